// File: doc/BRIEF.md
# Maskable Interrupt Status Controller

This block collects single-cycle event pulses from a network controller's receive path, transmit path, host-bus error detectors and PHY into a 32-bit status word. Software reads that word over a simple register bus and clears handled events by writing ones to them. A 16-bit mask selects which of the low sixteen latched events may raise the single interrupt line. A separate control word holds a global enable, a software-forced interrupt and a self-clearing soft reset.

The upper half of the status word carries the current interrupt level, two live idle indications that are not latched, and four latched host-bus error flags. Any host-bus error also latches the fatal event in the low half, so it can be masked and cleared like any other event.

Top module: `irq_status_ctrl`

## Requirements
- R1: After reset the status word (with both idle inputs low), the mask word and the control word all read 0, and `irq_o` is 0.
- R2: A one-cycle pulse on `evt_pulse[i]` (i in 0..12 or 15) sets status bit i, visible after the next rising clock edge, and the bit stays set until cleared.
- R3: A write to the status word (offset 0x04) clears each latched bit written as 1 in an enabled byte; bits written as 0 keep their value.
- R4: When an event pulse and a clear of the same bit meet in one cycle, the bit remains set.
- R5: `irq_o` equals control bit 1 (enable) AND the OR of control bit 2 and every status bit 0..15 ANDed with the mask bit at the same position of the mask word (offset 0x08).
- R6: Status bit 16 always reads the current value of `irq_o`.
- R7: Status bits 17 and 18 show `rx_idle` and `tx_idle` as they are in the same cycle; writes to the status word do not change them.
- R8: A pulse on `pci_err_pulse[k]` latches status bit 24+k (0 data parity, 1 address parity, 2 master abort, 3 target abort) and also sets status bit 12; bits 24..27 clear by writing 1.
- R9: Control word (offset 0x0c) bit 2 set together with bit 1 raises `irq_o` with no event latched and no mask bit set.
- R10: Writing 1 to control bit 0 clears every latched status bit, the mask word and the control word on the next edge; control bit 0 always reads 0.
- R11: Only bytes with their `reg_strb` bit set are written; status bits 13, 14, 19..23 and 28..31 always read 0 and pulses on `evt_pulse[13]`/`evt_pulse[14]` are ignored.
- R12: Reads of any offset other than 0x04, 0x08 and 0x0c return 0, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W | Byte offset of the register access |
| reg_wr | input | 1 | Write request for the current cycle |
| reg_strb | input | 4 | Byte enables of the write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| evt_pulse | input | 16 | One-cycle event pulses, bit i sets status bit i |
| pci_err_pulse | input | 4 | One-cycle host-bus error pulses |
| rx_idle | input | 1 | Live receive idle flag |
| tx_idle | input | 1 | Live transmit idle flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default 8-bit register address, which places the three registers and an unused offset within a single byte and lets every decode path, including the unmapped one, be reached. With the status and mask widths fixed at sixteen maskable bits and four error bits, a single all-ones pulse covers the reserved bits 13 and 14, and partial byte strobes exercise the split between the two mask bytes. The collision of a pulse with its own clear, the error-to-fatal link and soft reset taking precedence over pending events are each driven in a dedicated scenario.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int DATA_W = 32;
    localparam int LO_W   = 16;
    localparam int PCI_W  = 4;
    localparam int STRB_W = DATA_W / 8;

    localparam logic [7:0] OFF_STATUS = 8'h04;
    localparam logic [7:0] OFF_MASK   = 8'h08;
    localparam logic [7:0] OFF_CTL    = 8'h0c;

    localparam int BIT_FATAL   = 12;
    localparam int BIT_ACTIVE  = 16;
    localparam int BIT_RXIDLE  = 17;
    localparam int BIT_TXIDLE  = 18;
    localparam int BIT_PCI_LSB = 24;

    localparam int CTL_SRST = 0;
    localparam int CTL_EN   = 1;
    localparam int CTL_SWI  = 2;

    localparam logic [LO_W-1:0] LO_VALID = 16'h9fff;

    typedef struct packed {
        logic [LO_W-1:0] mask;
        logic            en;
        logic            swi;
    } ctl_state_t;
endpackage

// File: rtl/irq_w1c_latch.sv
module irq_w1c_latch #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         srst_i,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] q_o
);
    typedef struct packed {
        logic [W-1:0] bits;
    } latch_state_t;

    latch_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (srst_i) begin
            st_d.bits = '0;
        end else begin
            st_d.bits = (st_q.bits & ~clr_i) | set_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign q_o = st_q.bits;

    AST_EVT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (!srst_i && (|set_i)) |=> ((q_o & $past(set_i)) == $past(set_i))); // R4

    AST_EVT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !srst_i |=> ((q_o & $past(q_o & ~clr_i)) == $past(q_o & ~clr_i))); // R2

    AST_SRST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        srst_i |=> (q_o == '0)); // R10
endmodule

// File: rtl/irq_ctl_regs.sv
module irq_ctl_regs
    import irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_mask_i,
    input  logic              wr_ctl_i,
    input  logic [STRB_W-1:0] strb_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              srst_o,
    output logic [LO_W-1:0]   mask_o,
    output logic              en_o,
    output logic              swi_o
);
    ctl_state_t st_d, st_q;
    logic       srst;

    assign srst = wr_ctl_i && strb_i[0] && wdata_i[CTL_SRST];

    always_comb begin
        st_d = st_q;
        if (srst) begin
            st_d = '0;
        end else begin
            if (wr_mask_i) begin
                for (int b = 0; b < LO_W / 8; b++) begin
                    if (strb_i[b]) begin
                        st_d.mask[b*8 +: 8] = wdata_i[b*8 +: 8];
                    end
                end
            end
            if (wr_ctl_i && strb_i[0]) begin
                st_d.en  = wdata_i[CTL_EN];
                st_d.swi = wdata_i[CTL_SWI];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign srst_o = srst;
    assign mask_o = st_q.mask;
    assign en_o   = st_q.en;
    assign swi_o  = st_q.swi;

    AST_SRST_CTL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        srst_o |=> (mask_o == '0 && !en_o && !swi_o)); // R10

    AST_MASK_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_mask_i && !srst_o) |=> $stable(mask_o)); // R12
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
    import irq_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [3:0]        reg_strb,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [15:0]       evt_pulse,
    input  logic [3:0]        pci_err_pulse,
    input  logic              rx_idle,
    input  logic              tx_idle,
    output logic              irq_o
);
    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFF_STATUS);
    localparam logic [ADDR_W-1:0] A_MASK   = ADDR_W'(OFF_MASK);
    localparam logic [ADDR_W-1:0] A_CTL    = ADDR_W'(OFF_CTL);

    logic              sel_status, sel_mask, sel_ctl;
    logic              srst;
    logic [LO_W-1:0]   mask, lo_q, lo_set, lo_clr;
    logic [PCI_W-1:0]  pci_q, pci_clr;
    logic              en, swi;
    logic [DATA_W-1:0] status_word, ctl_word;

    assign sel_status = (reg_addr == A_STATUS);
    assign sel_mask   = (reg_addr == A_MASK);
    assign sel_ctl    = (reg_addr == A_CTL);

    always_comb begin
        lo_set = evt_pulse & LO_VALID;
        lo_set[BIT_FATAL] = evt_pulse[BIT_FATAL] | (|pci_err_pulse);
        lo_clr = '0;
        pci_clr = '0;
        if (reg_wr && sel_status) begin
            for (int b = 0; b < LO_W / 8; b++) begin
                if (reg_strb[b]) begin
                    lo_clr[b*8 +: 8] = reg_wdata[b*8 +: 8];
                end
            end
            if (reg_strb[BIT_PCI_LSB / 8]) begin
                pci_clr = reg_wdata[BIT_PCI_LSB +: PCI_W];
            end
        end
    end

    irq_ctl_regs i_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_mask_i (reg_wr && sel_mask),
        .wr_ctl_i  (reg_wr && sel_ctl),
        .strb_i    (reg_strb),
        .wdata_i   (reg_wdata),
        .srst_o    (srst),
        .mask_o    (mask),
        .en_o      (en),
        .swi_o     (swi)
    );

    irq_w1c_latch #(.W(LO_W)) i_lo (
        .clk    (clk),
        .rst_n  (rst_n),
        .srst_i (srst),
        .set_i  (lo_set),
        .clr_i  (lo_clr),
        .q_o    (lo_q)
    );

    irq_w1c_latch #(.W(PCI_W)) i_pci (
        .clk    (clk),
        .rst_n  (rst_n),
        .srst_i (srst),
        .set_i  (pci_err_pulse),
        .clr_i  (pci_clr),
        .q_o    (pci_q)
    );

    assign irq_o = en && (swi || (|(lo_q & mask)));

    always_comb begin
        status_word = '0;
        status_word[LO_W-1:0] = lo_q;
        status_word[BIT_ACTIVE] = irq_o;
        status_word[BIT_RXIDLE] = rx_idle;
        status_word[BIT_TXIDLE] = tx_idle;
        status_word[BIT_PCI_LSB +: PCI_W] = pci_q;
        ctl_word = '0;
        ctl_word[CTL_EN]  = en;
        ctl_word[CTL_SWI] = swi;
        if (sel_status) begin
            reg_rdata = status_word;
        end else if (sel_mask) begin
            reg_rdata = {{(DATA_W-LO_W){1'b0}}, mask};
        end else if (sel_ctl) begin
            reg_rdata = ctl_word;
        end else begin
            reg_rdata = '0;
        end
    end

    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> en); // R5

    AST_PCI_SETS_FATAL: assert property (@(posedge clk) disable iff (!rst_n)
        ((|pci_err_pulse) && !srst) |=> lo_q[BIT_FATAL]); // R8

    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_q[13] == 1'b0 && lo_q[14] == 1'b0)); // R11
endmodule

// File: tb/test_irq_status_ctrl.sv
`timescale 1ns/1ps
module test_irq_status_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_strb = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [15:0] evt_pulse = '0;
    logic [3:0]  pci_err_pulse = '0;
    logic        rx_idle = 1'b0;
    logic        tx_idle = 1'b0;
    logic        irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    irq_status_ctrl i_irq_status_ctrl (
        .clk, .rst_n, .reg_addr, .reg_wr, .reg_strb, .reg_wdata, .reg_rdata,
        .evt_pulse, .pci_err_pulse, .rx_idle, .tx_idle, .irq_o
    );

    localparam logic [7:0] ST = 8'h04, MK = 8'h08, CT = 8'h0c;

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] s);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_strb = s; reg_wr = 1'b1;
        @(posedge clk); #1;
        reg_wr = 1'b0; reg_strb = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic pulse(input logic [15:0] e, input logic [3:0] p);
        @(negedge clk);
        evt_pulse = e; pci_err_pulse = p;
        @(posedge clk); #1;
        evt_pulse = '0; pci_err_pulse = '0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(ST, d); chk("R1 status", d, 32'h0);
        rd(MK, d); chk("R1 mask", d, 32'h0);
        rd(CT, d); chk("R1 ctl", d, 32'h0);
        chk("R1 irq", {31'b0, irq_o}, 32'h0);
    endtask

    task automatic t_latch();
        logic [31:0] d;
        pulse(16'h0020, 4'h0);
        rd(ST, d); chk("R2 set", d, 32'h20);
        rd(ST, d); chk("R2 hold", d, 32'h20);
        wr(ST, 32'h0, 4'hf);
        rd(ST, d); chk("R3 zero write keeps", d, 32'h20);
        wr(ST, 32'h20, 4'hf);
        rd(ST, d); chk("R3 clear", d, 32'h0);
    endtask

    task automatic t_collide();
        logic [31:0] d;
        pulse(16'h0001, 4'h0);
        @(negedge clk);
        reg_addr = ST; reg_wdata = 32'h1; reg_strb = 4'hf; reg_wr = 1'b1;
        evt_pulse = 16'h0001;
        @(posedge clk); #1;
        reg_wr = 1'b0; reg_strb = '0; evt_pulse = '0;
        rd(ST, d); chk("R4 collision", d, 32'h1);
        wr(ST, 32'h1, 4'hf);
    endtask

    task automatic t_mask();
        logic [31:0] d;
        pulse(16'h0080, 4'h0);
        chk("R5 disabled", {31'b0, irq_o}, 32'h0);
        wr(MK, 32'h80, 4'hf);
        chk("R5 masked but not enabled", {31'b0, irq_o}, 32'h0);
        wr(CT, 32'h2, 4'hf);
        chk("R5 enabled", {31'b0, irq_o}, 32'h1);
        rd(ST, d); chk("R6 active bit", d, 32'h10080);
        wr(MK, 32'h40, 4'hf);
        chk("R5 other mask", {31'b0, irq_o}, 32'h0);
        rd(ST, d); chk("R6 active low", d, 32'h80);
        wr(ST, 32'h80, 4'hf);
    endtask

    task automatic t_swint();
        wr(CT, 32'h6, 4'hf);
        chk("R9 sw irq", {31'b0, irq_o}, 32'h1);
        wr(CT, 32'h4, 4'hf);
        chk("R9 sw irq no enable", {31'b0, irq_o}, 32'h0);
        wr(CT, 32'h0, 4'hf);
    endtask

    task automatic t_live();
        logic [31:0] d;
        @(negedge clk); rx_idle = 1'b1;
        rd(ST, d); chk("R7 rx idle", d, 32'h20000);
        @(negedge clk); tx_idle = 1'b1;
        rd(ST, d); chk("R7 both idle", d, 32'h60000);
        wr(ST, 32'hffffffff, 4'hf);
        rd(ST, d); chk("R7 write ignored", d, 32'h60000);
        @(negedge clk); rx_idle = 1'b0; tx_idle = 1'b0;
        rd(ST, d); chk("R7 follows", d, 32'h0);
    endtask

    task automatic t_pci();
        logic [31:0] d;
        pulse(16'h0, 4'h4);
        rd(ST, d); chk("R8 master abort", d, 32'h04001000);
        wr(ST, 32'h04000000, 4'h8);
        rd(ST, d); chk("R8 clear error", d, 32'h1000);
        wr(ST, 32'h1000, 4'h2);
        rd(ST, d); chk("R8 clear fatal", d, 32'h0);
    endtask

    task automatic t_strobe();
        logic [31:0] d;
        wr(MK, 32'hffff, 4'h1);
        rd(MK, d); chk("R11 low byte only", d, 32'h00ff);
        pulse(16'hffff, 4'h0);
        rd(ST, d); chk("R11 reserved ignored", d, 32'h9fff);
        wr(ST, 32'hffff, 4'h2);
        rd(ST, d); chk("R11 clear high byte", d, 32'h00ff);
    endtask

    task automatic t_srst();
        logic [31:0] d;
        wr(CT, 32'h2, 4'hf);
        pulse(16'h0, 4'h1);
        chk("R10 pre irq", {31'b0, irq_o}, 32'h1);
        wr(CT, 32'h3, 4'h1);
        rd(ST, d); chk("R10 status", d, 32'h0);
        rd(MK, d); chk("R10 mask", d, 32'h0);
        rd(CT, d); chk("R10 ctl", d, 32'h0);
        chk("R10 irq", {31'b0, irq_o}, 32'h0);
    endtask

    task automatic t_addr();
        logic [31:0] d;
        wr(MK, 32'h1234, 4'hf);
        wr(8'h10, 32'hffff, 4'hf);
        rd(8'h10, d); chk("R12 unmapped read", d, 32'h0);
        rd(MK, d); chk("R12 mask untouched", d, 32'h1234);
        wr(MK, 32'h0, 4'hf);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_latch();
        t_collide();
        t_mask();
        t_swint();
        t_live();
        t_pci();
        t_strobe();
        t_srst();
        t_addr();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule